// File: doc/BRIEF.md
# Multidrop Device Pause-State Controller

This block holds the power and selection state of one device that shares a single-wire bus with other devices of the same kind. It receives already-decoded single-cycle strobes: a wake-token detect, a pause command with an address field that may be absent, and a watchdog expiry. It also receives the device's own address as programmed in fuses. From these it keeps the device in one of three states: sleep, active or pause.

A host uses the pause state to pick out one device on a shared wire. It sends pause commands addressed to every device except the one it wants to talk to. An addressed device parks in pause. While parked, it ignores all bus activity, and it leaves pause only when its watchdog expires, which puts it to sleep. The one device that was not addressed stays active and keeps listening. Once every watchdog has expired, all devices are asleep and the next wake token reaches all of them again.

The block drives a listen enable that gates the downstream command decoder, and a low-power indication. Pause is not a low-power state.

Top module: `devPauseTop`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, the state output is sleep, lowPower is 1 and listenEn is 0.
- R2: In sleep, a wakeTok pulse moves the state to active on the next clock edge.
- R3: In active, a pauseCmd with addrPresent=1 and cmdAddr equal to fuseAddr moves the state to pause on the next clock edge, provided wdExpire is low.
- R4: In active, a pauseCmd with addrPresent=1 and cmdAddr different from fuseAddr leaves the state active, and listenEn stays 1.
- R5: In active, a pauseCmd with addrPresent=0 is treated as an address match and moves the state to pause.
- R6: In pause, wakeTok and pauseCmd have no effect, whatever the address. The state stays pause until wdExpire.
- R7: In pause, lowPower is 0 and listenEn is 0.
- R8: In pause, a wdExpire pulse moves the state to sleep on the next clock edge.
- R9: In active, wdExpire moves the state to sleep on the next clock edge. It takes priority over a pauseCmd in the same cycle.
- R10: In sleep, pauseCmd and wdExpire have no effect. Only wakeTok leaves sleep.
- R11: devState encodes sleep as 2'b00, active as 2'b01 and pause as 2'b10, and never shows 2'b11. listenEn is 1 only in active, and lowPower is 1 only in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeTok | input | 1 | Single-cycle wake-token detect from the line decoder |
| pauseCmd | input | 1 | Single-cycle strobe for a decoded pause command |
| addrPresent | input | 1 | The pause command carries an address field |
| cmdAddr | input | AW | Address field of the pause command |
| fuseAddr | input | AW | Device address from fuses |
| wdExpire | input | 1 | Single-cycle watchdog expiry pulse |
| devState | output | 2 | Current state: 00 sleep, 01 active, 10 pause |
| listenEn | output | 1 | Enables the command decoder; high only in active |
| lowPower | output | 1 | Low-power indication; high only in sleep |

## Verification
The properties assume the following about the inputs:
- Every strobe lasts one cycle and is sampled on the clock edge.
- fuseAddr is steady.
- cmdAddr and addrPresent are meaningful only when pauseCmd is high.
- pauseCmd and wdExpire may coincide.

The properties do not assume that strobes are exclusive. The stimulus drives inputs on the falling edge. It covers every combination of coincident strobes, including a watchdog expiry together with a pause command, and uses both matching and mismatching addresses with and without an address field. A phase of random strobes then runs against the reference model.

// File: rtl/devPausePkg.sv
package devPausePkg;
  typedef enum logic [1:0] {
    ST_SLEEP  = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_PAUSE  = 2'b10
  } devStateE;

  typedef struct packed {
    logic goSleep;
    logic goActive;
    logic goPause;
  } stateStrobeS;
endpackage

// File: rtl/devPauseDp.sv
module devPauseDp
  import devPausePkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrPresent,
  input  logic [AW-1:0] cmdAddr,
  input  logic [AW-1:0] fuseAddr,
  input  stateStrobeS   strobe,
  output logic          addrHit,
  output devStateE      curState,
  output logic          listenEn,
  output logic          lowPower
);
  // A pause command with no address field selects every device.
  always_comb addrHit = !addrPresent || (cmdAddr == fuseAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 curState <= ST_SLEEP;
    else if (strobe.goSleep)   curState <= ST_SLEEP;
    else if (strobe.goPause)   curState <= ST_PAUSE;
    else if (strobe.goActive)  curState <= ST_ACTIVE;
  end

  always_comb begin
    listenEn = (curState == ST_ACTIVE);
    lowPower = (curState == ST_SLEEP);
  end
endmodule

// File: rtl/devPauseCtl.sv
module devPauseCtl
  import devPausePkg::*;
(
  input  devStateE    curState,
  input  logic        wakeTok,
  input  logic        pauseCmd,
  input  logic        wdExpire,
  input  logic        addrHit,
  output stateStrobeS strobe
);
  always_comb begin
    strobe = '0;
    unique case (curState)
      ST_SLEEP:  strobe.goActive = wakeTok;
      ST_ACTIVE: begin
        strobe.goSleep = wdExpire;
        strobe.goPause = !wdExpire && pauseCmd && addrHit;
      end
      ST_PAUSE:  strobe.goSleep = wdExpire;
      default:   strobe.goSleep = 1'b1;
    endcase
  end
endmodule

// File: rtl/devPauseTop.sv
module devPauseTop
  import devPausePkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wakeTok,
  input  logic          pauseCmd,
  input  logic          addrPresent,
  input  logic [AW-1:0] cmdAddr,
  input  logic [AW-1:0] fuseAddr,
  input  logic          wdExpire,
  output logic [1:0]    devState,
  output logic          listenEn,
  output logic          lowPower
);
  stateStrobeS strobe;
  devStateE    curState;
  logic        addrHit;

  devPauseCtl uCtl (
    .curState(curState), .wakeTok(wakeTok), .pauseCmd(pauseCmd),
    .wdExpire(wdExpire), .addrHit(addrHit), .strobe(strobe)
  );

  devPauseDp #(.AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .addrPresent(addrPresent), .cmdAddr(cmdAddr),
    .fuseAddr(fuseAddr), .strobe(strobe), .addrHit(addrHit),
    .curState(curState), .listenEn(listenEn), .lowPower(lowPower)
  );

  always_comb devState = curState;
endmodule

// File: rtl/devPauseChk.sv
module devPauseChk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          wakeTok,
  input logic          pauseCmd,
  input logic          addrPresent,
  input logic [AW-1:0] cmdAddr,
  input logic [AW-1:0] fuseAddr,
  input logic          wdExpire,
  input logic [1:0]    devState,
  input logic          listenEn,
  input logic          lowPower
);
  localparam logic [1:0] SL = 2'b00, AC = 2'b01, PA = 2'b10;

  // R2
  wake_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == SL && wakeTok) |=> devState == AC);
  // R3
  pause_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == AC && pauseCmd && addrPresent && cmdAddr == fuseAddr && !wdExpire) |=> devState == PA);
  // R4
  pause_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == AC && pauseCmd && addrPresent && cmdAddr != fuseAddr && !wdExpire) |=> (devState == AC && listenEn));
  // R5
  pause_noaddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == AC && pauseCmd && !addrPresent && !wdExpire) |=> devState == PA);
  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == PA && !wdExpire) |=> devState == PA);
  // R7
  pause_outs_chk: assert property (@(posedge clk) disable iff (!rstN)
    devState == PA |-> (!lowPower && !listenEn));
  // R8
  pause_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == PA && wdExpire) |=> devState == SL);
  // R9
  active_wd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == AC && wdExpire) |=> devState == SL);
  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devState == SL && !wakeTok) |=> devState == SL);
  // R11
  encode_chk: assert property (@(posedge clk) disable iff (!rstN)
    devState != 2'b11 && $onehot0({listenEn, lowPower}));
endmodule

bind devPauseTop devPauseChk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .wakeTok(wakeTok), .pauseCmd(pauseCmd),
  .addrPresent(addrPresent), .cmdAddr(cmdAddr), .fuseAddr(fuseAddr),
  .wdExpire(wdExpire), .devState(devState), .listenEn(listenEn),
  .lowPower(lowPower)
);

// File: tb/tb_devPauseTop.sv
`timescale 1ns/1ps
module tb_devPauseTop;
  localparam int AW = 4;
  localparam logic [AW-1:0] FUSE = 4'hA;

  logic clk = 1'b0, rstN = 1'b0;
  logic wakeTok = 0, pauseCmd = 0, addrPresent = 0, wdExpire = 0;
  logic [AW-1:0] cmdAddr = '0;
  logic [AW-1:0] fuseAddr = FUSE;
  logic [1:0] devState;
  logic listenEn, lowPower;

  int checks = 0, errors = 0;
  int model = 0; // 0 sleep, 1 active, 2 pause
  bit done = 0;

  always #10 clk = ~clk;

  devPauseTop #(.AW(AW)) dut (
    .clk(clk), .rstN(rstN), .wakeTok(wakeTok), .pauseCmd(pauseCmd),
    .addrPresent(addrPresent), .cmdAddr(cmdAddr), .fuseAddr(fuseAddr),
    .wdExpire(wdExpire), .devState(devState), .listenEn(listenEn),
    .lowPower(lowPower)
  );

  function automatic int nextModel(int s, bit wk, bit pc, bit ap, logic [AW-1:0] ca, bit wd);
    if (s == 0) return wk ? 1 : 0;
    if (s == 2) return wd ? 0 : 2;
    if (wd) return 0;
    if (pc && (!ap || ca == FUSE)) return 2;
    return 1;
  endfunction

  task automatic compare(string req);
    int expState = model;
    bit expListen = (model == 1);
    bit expLow = (model == 0);
    checks++;
    if (devState !== expState[1:0] || listenEn !== expListen || lowPower !== expLow) begin
      errors++;
      $display("FAIL %s: state=%0d listen=%0b low=%0b expected state=%0d listen=%0b low=%0b",
               req, devState, listenEn, lowPower, expState, expListen, expLow);
    end
  endtask

  // Drive at negedge, let one rising edge pass, compare at the next negedge.
  task automatic cyc(bit wk, bit pc, bit ap, logic [AW-1:0] ca, bit wd, string req);
    wakeTok = wk; pauseCmd = pc; addrPresent = ap; cmdAddr = ca; wdExpire = wd;
    @(posedge clk);
    model = nextModel(model, wk, pc, ap, ca, wd);
    @(negedge clk);
    wakeTok = 0; pauseCmd = 0; addrPresent = 0; cmdAddr = '0; wdExpire = 0;
    compare(req);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");
    // R10: sleep ignores pause and watchdog
    cyc(0, 1, 1, FUSE, 0, "R10");
    cyc(0, 1, 0, 4'h0, 0, "R10");
    cyc(0, 0, 0, 4'h0, 1, "R10");
    cyc(0, 1, 1, FUSE, 1, "R10");
    // R2: wake
    cyc(1, 0, 0, 4'h0, 0, "R2");
    cyc(1, 0, 0, 4'h0, 0, "R11");
    // R4: mismatch stays active
    cyc(0, 1, 1, 4'h5, 0, "R4");
    cyc(0, 1, 1, 4'hB, 0, "R4");
    // R3: matching address
    cyc(0, 1, 1, FUSE, 0, "R3");
    // R6, R7: pause ignores everything but watchdog
    cyc(1, 0, 0, 4'h0, 0, "R6");
    cyc(0, 1, 1, FUSE, 0, "R6");
    cyc(1, 1, 1, 4'h3, 0, "R7");
    cyc(0, 1, 0, 4'h0, 0, "R6");
    // R8: watchdog leaves pause
    cyc(1, 0, 0, 4'h0, 1, "R8");
    // R5: no address field
    cyc(1, 0, 0, 4'h0, 0, "R2");
    cyc(0, 1, 0, 4'h7, 0, "R5");
    cyc(0, 0, 0, 4'h0, 1, "R8");
    // R9: watchdog wins over a matching pause
    cyc(1, 0, 0, 4'h0, 0, "R2");
    cyc(0, 1, 1, FUSE, 1, "R9");
    cyc(1, 0, 0, 4'h0, 0, "R2");
    cyc(0, 0, 0, 4'h0, 1, "R9");
    // Random phase, model compared every clock (R11)
    for (int i = 0; i < 400; i++) begin
      bit wk = ($urandom % 4) == 0;
      bit pc = ($urandom % 3) == 0;
      bit ap = ($urandom % 4) != 0;
      logic [AW-1:0] ca = (($urandom % 2) == 0) ? FUSE : AW'($urandom);
      bit wd = ($urandom % 8) == 0;
      cyc(wk, pc, ap, ca, wd, "R11");
    end
    // R1: reset mid-operation
    cyc(1, 0, 0, 4'h0, 0, "R2");
    rstN = 1'b0;
    model = 0;
    @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule